// File: doc/BRIEF.md
# SMBus Alert-Response Responder

This block sits on the target side of an I2C bus. It watches for the one read that a host sends to find out which device raised a shared alert line. The block acts only while the local comparator alert latch reports a pending alert. In that case it acknowledges the command byte and then sends eight bits: its own 7-bit address, followed by one status bit. A status of 1 means the high threshold was crossed and 0 means the low threshold.

Several devices may answer at the same time. The reply goes out over the open-drain data line, so the line acts as a wired-AND and arbitration happens bit by bit. The device with the lowest reply word always wins. A device that loses releases the line and keeps its alert pending, so that a later alert-response read can serve it. Only the winner pulses a clear to its alert latch, and only after all eight reply bits have been sent.

The block does not handle ordinary register reads or writes, and it never stretches the clock. The bus inputs are oversampled by the system clock through a synchroniser. The single data-line output is a pull-low enable. There is no streaming data path, so every pin is a plain level or pulse with no valid/ready handshake.

Top module: `alert_reply_unit`

## Requirements
- R1: Out of reset, `sda_pull` and `alert_clear` are both low.
- R2: After a START, if the received byte is 0x19 (address 0001100, read bit 1, MSB first) and `alert_pending` is high, the block pulls SDA low for the whole ninth (acknowledge) clock.
- R3: If the received byte is anything other than 0x19, or `alert_pending` is low, the block never pulls SDA and gives no clear for the rest of that transaction.
- R4: After the acknowledge, the block sends the word {`own_addr`[6:0], `status_high`} MSB first. It pulls SDA low for a 0 bit and releases it for a 1 bit.
- R5: `sda_pull` changes only while SCL is low. SDA is sampled while SCL is high.
- R6: If the block releases SDA for a 1 bit but the line reads 0 at the SCL rise, the block has lost. It releases SDA for the rest of the transaction and gives no clear. With wired-AND arbitration, the lowest reply word ends up on the bus.
- R7: `alert_clear` is a single-cycle pulse. It is given once, at the rise of the eighth reply bit, and only if arbitration was never lost.
- R8: A START or a STOP at any point returns the block to its initial state. SDA is released and no clear is given. A new START begins address reception again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| own_addr | input | 7 | This device's 7-bit bus address |
| alert_pending | input | 1 | Comparator alert latch is set |
| status_high | input | 1 | 1 = high threshold crossed, 0 = low threshold crossed |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| alert_clear | output | 1 | One-cycle pulse that clears the alert latch after a won reply |

## Verification
The hardest situation to reach is losing arbitration partway through the reply. It needs a second responder driving the same open-drain line in step with the block. The bench models that competitor, with its own reply word, as a behavioural driver that is ANDed into `sda_in`. It draws the two addresses and status bits at random, and adds directed pairs that differ only in the last address bit or only in the status bit. An early STOP in the middle of the reply, and a repeated START in the middle of the address byte, are driven at bit positions where the block is known to have released the line, so that the master can actually make the line transition.

// File: rtl/alert_reply_pkg.sv
package alert_reply_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ARM,
    ST_ACK_HOLD,
    ST_REPLY,
    ST_DONE
  } rsp_state_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/reply_engine.sv
module reply_engine
  import alert_reply_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] RESP_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              alert_pending,
  input  logic              status_high,
  output logic              sda_pull,
  output logic              alert_clear
);
  localparam int WORD_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [WORD_W-1:0] RESP_BYTE = {RESP_ADDR, 1'b1};

  rsp_state_t        st_q;
  logic [CNT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] word_q;
  logic              pull_q;
  logic              clear_q;
  logic [WORD_W-1:0] rx_byte;
  logic              lose_now;

  assign rx_byte  = {shift_q[WORD_W-2:0], sda_lvl};
  assign lose_now = word_q[WORD_W-1] & ~sda_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_idx <= '0;
      shift_q <= '0;
      word_q  <= '1;
      pull_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      clear_q <= 1'b0;
      if (start_evt) begin
        st_q    <= ST_ADDR;
        bit_idx <= '0;
        pull_q  <= 1'b0;
      end else if (stop_evt) begin
        st_q   <= ST_IDLE;
        pull_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: if (scl_rise) begin
            shift_q <= rx_byte;
            if (bit_idx == LAST_IDX) begin
              bit_idx <= '0;
              st_q    <= (rx_byte == RESP_BYTE && alert_pending) ? ST_ACK_ARM : ST_DONE;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
          ST_ACK_ARM: if (scl_fall) begin
            pull_q <= 1'b1;
            st_q   <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            word_q  <= {own_addr, status_high};
            pull_q  <= ~own_addr[ADDR_W-1];
            bit_idx <= '0;
            st_q    <= ST_REPLY;
          end
          ST_REPLY: begin
            if (scl_rise) begin
              if (lose_now) begin
                st_q <= ST_DONE;
              end else if (bit_idx == LAST_IDX) begin
                clear_q <= 1'b1;
                st_q    <= ST_DONE;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else if (scl_fall) begin
              word_q <= {word_q[WORD_W-2:0], 1'b1};
              pull_q <= ~word_q[WORD_W-2];
            end
          end
          ST_DONE: if (scl_fall) pull_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign sda_pull    = pull_q;
  assign alert_clear = clear_q;

  // R5: the data line drive is held while the clock line stays high
  p_pull_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(pull_q));

  // R7: clear is a single-cycle pulse
  p_clear_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_q |=> !clear_q);

  // R6: a lost bit never leads to a clear
  p_no_clear_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REPLY && scl_rise && lose_now && !start_evt && !stop_evt) |=> !clear_q);

  // R3: without a pending alert the command byte is not acknowledged
  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && scl_rise && bit_idx == LAST_IDX && !alert_pending
     && !start_evt && !stop_evt) |=> (st_q == ST_DONE && !pull_q));

  // R8: STOP releases the line
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!pull_q && st_q == ST_IDLE));
endmodule

// File: rtl/alert_reply_unit.sv
module alert_reply_unit #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              alert_pending,
  input  logic              status_high,
  output logic              sda_pull,
  output logic              alert_clear
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  reply_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_s), .sda_lvl(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_addr), .alert_pending(alert_pending),
    .status_high(status_high),
    .sda_pull(sda_pull), .alert_clear(alert_clear));
endmodule

// File: tb/alert_reply_unit_test.sv
module alert_reply_unit_test;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, c_sda = 1'b1;
  logic [6:0] own_addr = 7'h00;
  logic alert_pending = 1'b0, status_high = 1'b0;
  logic sda_pull, alert_clear;
  logic sda_bus;

  int checks = 0, fails = 0, clr_cnt = 0, viol = 0, cyc = 0;
  logic prev_pull = 1'b0, prev_scl = 1'b1;

  always #5 clk = ~clk;

  assign sda_bus = m_sda & c_sda & ~sda_pull;

  alert_reply_unit uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .own_addr(own_addr), .alert_pending(alert_pending),
    .status_high(status_high), .sda_pull(sda_pull), .alert_clear(alert_clear));

  always @(negedge clk) begin
    if (alert_clear) clr_cnt++;
    if (m_scl && prev_scl && sda_pull !== prev_pull) viol++;
    prev_pull <= sda_pull;
    prev_scl  <= m_scl;
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic clock_bit(output logic s);
    half(); m_scl = 1'b1; half(); s = sda_bus; m_scl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_cond();
    m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic stop_cond();
    m_sda = 1'b0; c_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
  endtask

  function automatic logic [7:0] exp_reply(logic ua, logic ca, logic [7:0] uw, logic [7:0] cw);
    if (ua && ca) return (uw < cw) ? uw : cw;
    if (ua) return uw;
    if (ca) return cw;
    return 8'hFF;
  endfunction

  // stop_after < 8 ends the reply early with a STOP; glitch sends a partial byte then a repeated START
  task automatic run_txn(input logic [7:0] cmd, input logic pend, input logic [6:0] ua,
                         input logic us, input logic cen, input logic [6:0] ca,
                         input logic cs, input int stop_after, input logic glitch);
    logic s, ack, c_lost, u_act, c_act;
    logic [7:0] rd, uw, cw;
    int base;
    own_addr = ua; alert_pending = pend; status_high = us;
    uw = {ua, us}; cw = {ca, cs};
    u_act = (cmd == 8'h19) && pend;
    c_act = (cmd == 8'h19) && cen;
    base = clr_cnt;
    c_lost = 1'b0; rd = 8'h00;
    start_cond();
    if (glitch) begin
      for (int i = 7; i >= 4; i--) begin m_sda = 8'h19 >> i; clock_bit(s); end
      start_cond();
    end
    for (int i = 7; i >= 0; i--) begin m_sda = cmd[i]; clock_bit(s); end
    m_sda = 1'b1;
    if (c_act) c_sda = 1'b0;
    clock_bit(ack);
    c_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (7 - i >= stop_after) break;
      if (c_act && !c_lost) c_sda = cw[i];
      clock_bit(s);
      if (c_act && !c_lost && cw[i] && !s) c_lost = 1'b1;
      rd[i] = s;
    end
    c_sda = 1'b1;
    if (stop_after >= 8) begin
      m_sda = 1'b1; clock_bit(s);
      stop_cond();
      check(ack == !(u_act || c_act), u_act ? "R2 ack" : "R3 ack", ack, !(u_act || c_act));
      check(rd == exp_reply(u_act, c_act, uw, cw), "R4/R6 reply", rd, exp_reply(u_act, c_act, uw, cw));
      check((clr_cnt - base) == ((u_act && (!c_act || uw <= cw)) ? 1 : 0), "R7/R6 clear",
            clr_cnt - base, (u_act && (!c_act || uw <= cw)) ? 1 : 0);
    end else begin
      stop_cond();
      check((clr_cnt - base) == 0, "R8 no clear after stop", clr_cnt - base, 0);
    end
    check(sda_pull == 1'b0, "R8 released after stop", sda_pull, 0);
    half();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sda_pull == 1'b0 && alert_clear == 1'b0, "R1 during reset", {sda_pull, alert_clear}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sda_pull == 1'b0 && alert_clear == 1'b0, "R1 after reset", {sda_pull, alert_clear}, 0);

    // directed corner cases
    run_txn(8'h19, 1, 7'h48, 1, 0, 7'h00, 0, 8, 0);  // alone, status high (R4)
    run_txn(8'h19, 1, 7'h48, 0, 0, 7'h00, 0, 8, 0);  // status low (R4)
    run_txn(8'h19, 0, 7'h48, 1, 0, 7'h00, 0, 8, 0);  // not pending (R3)
    run_txn(8'h18, 1, 7'h48, 1, 0, 7'h00, 0, 8, 0);  // write bit (R3)
    run_txn(8'h19, 1, 7'h49, 0, 1, 7'h48, 1, 8, 0);  // lose on address LSB (R6)
    run_txn(8'h19, 1, 7'h48, 1, 1, 7'h49, 0, 8, 0);  // win on address LSB (R6)
    run_txn(8'h19, 1, 7'h30, 1, 1, 7'h30, 0, 8, 0);  // lose on status bit (R6)
    run_txn(8'h19, 1, 7'h30, 0, 1, 7'h30, 1, 8, 0);  // win on status bit (R6)
    run_txn(8'h19, 1, 7'h7F, 1, 1, 7'h00, 0, 8, 0);  // lose on first bit (R6)
    run_txn(8'h19, 1, 7'h55, 1, 0, 7'h00, 0, 2, 0);  // STOP mid reply (R8)
    run_txn(8'h19, 1, 7'h22, 0, 0, 7'h00, 0, 8, 1);  // repeated START mid address (R8)
    run_txn(8'h19, 0, 7'h22, 0, 1, 7'h10, 1, 8, 0);  // only competitor answers (R3)

    // constrained random
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 40; n++) begin
      logic [7:0] cmd;
      cmd = ($urandom % 4 != 0) ? 8'h19 : 8'($urandom);
      run_txn(cmd, 1'($urandom % 4 != 0), 7'($urandom), 1'($urandom),
              1'($urandom), 7'($urandom), 1'($urandom), 8, 0);
    end

    check(viol == 0, "R5 pull changed with SCL high", viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule